// File: doc/BRIEF.md
# Serial Calendar Clock

This block is a calendar clock reached over a three-wire serial link plus a strobe. It keeps seconds, minutes, hours, day of month, month, day of week and a two-digit year. A one-per-second enable advances the time. The host talks to it with a 4-bit command. The host shifts the command in bit by bit on the serial clock and then latches it with a strobe pulse. The command puts the block in one of four modes: idle, shifting, setting the time, or snapshotting the time.

To read the time, the host first issues a snapshot command, which copies the counters into a 48-bit data register. It then issues a shift command and collects 48 bits from the serial output, pulsing the serial clock after each sample. To set the time, the host issues a shift command and clocks in 48 bits. It then sends the set command, which loads the counters and freezes them, and finally an idle command, which lets them run again. All inputs are synchronous to the system clock. Edges on the serial clock and the strobe are found by comparing each input with its value one cycle earlier.

Top module: `serial_calendar_clock`

## Requirements
- R1: After reset, do_o is 0, the block is in idle mode and not frozen, and the counters read as 00:00:00, day 01, month 1, weekday 0, year 00.
- R2: A command is 4 bits, least significant bit first. Each bit is taken from di_i on a rising edge of sclk_i. A rising edge of stb_i while sclk_i is low latches the 4 bits as the new command. A strobe edge while sclk_i is high is ignored.
- R3: Command 0 selects idle, 1 selects shifting, 2 loads the counters from the data register and freezes them, and 3 copies the counters into the data register. Codes 4 to 15 act as idle.
- R4: The data word is laid out as follows. Bits 7:0 hold seconds, 15:8 minutes, 23:16 hours, 31:24 day and 47:40 year, all in BCD. Bits 39:36 hold the month in binary (1 to 12) and bits 35:32 the weekday (0 to 6). The word is streamed bit 0 first.
- R5: do_o always shows bit 0 of the data register. In shift mode, each sclk_i rising edge shifts the register right by one and puts di_i into bit 47. In any other mode, sclk_i edges leave do_o unchanged.
- R6: After a shift command, only the first 48 sclk_i rising edges move the data register. Later edges, such as the bits of the next command, do not disturb it.
- R7: Each tick_i pulse on an unfrozen clock advances the seconds in BCD. The carries run 59 to 00 for seconds into minutes, 59 to 00 for minutes into hours, and 23 to 00 for hours into the day.
- R8: The day rolls over to 01 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the BCD year is a multiple of 4 and 28 otherwise. All other months have 31 days. Month 12 wraps to 1 and advances the year, and year 99 wraps to 00.
- R9: The weekday advances whenever the hour wraps from 23 to 00, and it wraps from 6 to 0.
- R10: After a set command, tick_i has no effect until a later strobe latches any other command. That strobe releases the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-per-second advance enable, one cycle wide |
| sclk_i | input | 1 | Serial clock from the host |
| stb_i | input | 1 | Command strobe from the host |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, bit 0 of the data register |

## Verification
The bench targets the carry chain at its most demanding points. It checks a year-end wrap from 99 to 00 and February ends in a non-leap year, an even-tens leap year and an odd-tens leap year, and the end of a 30-day month. A wrong month-length table or a wrong leap test would land on the wrong date. It checks that a frozen clock stays put across ticks and that an unused command code releases it. A design that kept shifting past the 48-bit window would have the following command bits spill into the stored time. It checks that a strobe arriving while the serial clock is high does not load the time. It also checks that serial clock pulses outside shift mode do not move the output bit.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
package scc_pkg;

  localparam int unsigned CMD_W  = 4;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_SET   = 2'd2,
    MODE_SNAP  = 2'd3
  } scc_mode_e;

  // field order fixes the serial layout: sec leaves first
  typedef struct packed {
    logic [7:0] year;
    logic [3:0] month;
    logic [3:0] dow;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] sec;
  } cal_t;

  localparam int unsigned DATA_W = $bits(cal_t);

  localparam logic [7:0] SEC_LAST  = 8'h59;
  localparam logic [7:0] MIN_LAST  = 8'h59;
  localparam logic [7:0] HOUR_LAST = 8'h23;
  localparam logic [7:0] YEAR_LAST = 8'h99;
  localparam logic [3:0] MON_LAST  = 4'd12;
  localparam logic [3:0] DOW_LAST  = 4'd6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_days(input logic [3:0] m, input logic leap);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return 8'h30;
      4'd2:                    return leap ? 8'h29 : 8'h28;
      default:                 return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/scc_cmd_port.sv
`timescale 1ns/1ps
module scc_cmd_port #(
  parameter int unsigned CMD_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             stb_i,
  input  logic             di_i,
  output logic             sclk_rise_o,
  output logic             strobe_o,
  output logic [CMD_W-1:0] cmd_o
);

  logic             sclk_q;
  logic             stb_q;
  logic [CMD_W-1:0] cmd_sr_q;

  assign sclk_rise_o = sclk_i & ~sclk_q;
  // strobe only counts while the serial clock rests low
  assign strobe_o    = stb_i & ~stb_q & ~sclk_i;
  assign cmd_o       = cmd_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      stb_q    <= 1'b0;
      cmd_sr_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      stb_q  <= stb_i;
      if (sclk_rise_o) cmd_sr_q <= {di_i, cmd_sr_q[CMD_W-1:1]};
    end
  end

endmodule

// File: rtl/scc_mode_ctrl.sv
`timescale 1ns/1ps
module scc_mode_ctrl
  import scc_pkg::*;
#(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned DATA_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             sclk_rise_i,
  input  logic [CMD_W-1:0] cmd_i,
  output scc_mode_e        mode_o,
  output logic             held_o,
  output logic             load_o,
  output logic             snap_o,
  output logic             shift_step_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  scc_mode_e        mode_q, mode_dec;
  logic             held_q;
  logic [CNT_W-1:0] win_cnt_q;
  logic             win_open;

  always_comb begin
    if      (cmd_i == CMD_W'(1)) mode_dec = MODE_SHIFT;
    else if (cmd_i == CMD_W'(2)) mode_dec = MODE_SET;
    else if (cmd_i == CMD_W'(3)) mode_dec = MODE_SNAP;
    else                         mode_dec = MODE_IDLE;
  end

  assign win_open     = (mode_q == MODE_SHIFT) && (win_cnt_q < CNT_W'(DATA_W));
  assign shift_step_o = sclk_rise_i && win_open;
  assign load_o       = strobe_i && (mode_dec == MODE_SET);
  assign snap_o       = strobe_i && (mode_dec == MODE_SNAP);
  assign mode_o       = mode_q;
  assign held_o       = held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_IDLE;
      held_q    <= 1'b0;
      win_cnt_q <= '0;
    end else if (strobe_i) begin
      mode_q    <= mode_dec;
      held_q    <= (mode_dec == MODE_SET);
      win_cnt_q <= '0;
    end else if (shift_step_o) begin
      win_cnt_q <= win_cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/scc_shift_reg.sv
`timescale 1ns/1ps
module scc_shift_reg #(
  parameter int unsigned DATA_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_step_i,
  input  logic              di_i,
  input  logic              snap_i,
  input  logic [DATA_W-1:0] snap_val_i,
  output logic [DATA_W-1:0] data_o,
  output logic              do_o
);

  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sr_q <= '0;
    else if (snap_i)       sr_q <= snap_val_i;
    else if (shift_step_i) sr_q <= {di_i, sr_q[DATA_W-1:1]};
  end

  assign data_o = sr_q;
  assign do_o   = sr_q[0];

endmodule

// File: rtl/scc_calendar.sv
`timescale 1ns/1ps
module scc_calendar
  import scc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic held_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t cal_o
);

  cal_t       cal_q, cal_nxt;
  logic [7:0] last_day;

  assign last_day = month_days(cal_q.month, bcd_leap(cal_q.year));

  always_comb begin
    cal_nxt = cal_q;
    if (cal_q.sec != SEC_LAST) begin
      cal_nxt.sec = bcd_inc(cal_q.sec);
    end else begin
      cal_nxt.sec = 8'h00;
      if (cal_q.minute != MIN_LAST) begin
        cal_nxt.minute = bcd_inc(cal_q.minute);
      end else begin
        cal_nxt.minute = 8'h00;
        if (cal_q.hour != HOUR_LAST) begin
          cal_nxt.hour = bcd_inc(cal_q.hour);
        end else begin
          cal_nxt.hour = 8'h00;
          cal_nxt.dow  = (cal_q.dow >= DOW_LAST) ? 4'd0 : cal_q.dow + 4'd1;
          if (cal_q.day < last_day) begin
            cal_nxt.day = bcd_inc(cal_q.day);
          end else begin
            cal_nxt.day = 8'h01;
            if (cal_q.month < MON_LAST) begin
              cal_nxt.month = cal_q.month + 4'd1;
            end else begin
              cal_nxt.month = 4'd1;
              cal_nxt.year  = (cal_q.year == YEAR_LAST) ? 8'h00 : bcd_inc(cal_q.year);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q       <= '0;
      cal_q.day   <= 8'h01;
      cal_q.month <= 4'd1;
    end else if (load_i) begin
      cal_q <= load_val_i;
    end else if (tick_i && !held_i) begin
      cal_q <= cal_nxt;
    end
  end

  assign cal_o = cal_q;

endmodule

// File: rtl/serial_calendar_clock.sv
`timescale 1ns/1ps
module serial_calendar_clock
  import scc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sclk_i,
  input  logic stb_i,
  input  logic di_i,
  output logic do_o
);

  logic              sclk_rise;
  logic              strobe;
  logic [CMD_W-1:0]  cmd;
  scc_mode_e         mode;
  logic              held;
  logic              load;
  logic              snap;
  logic              shift_step;
  logic [DATA_W-1:0] sr_data;
  cal_t              cal_q;

  scc_cmd_port #(.CMD_W(CMD_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .stb_i       (stb_i),
    .di_i        (di_i),
    .sclk_rise_o (sclk_rise),
    .strobe_o    (strobe),
    .cmd_o       (cmd)
  );

  scc_mode_ctrl #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strobe_i     (strobe),
    .sclk_rise_i  (sclk_rise),
    .cmd_i        (cmd),
    .mode_o       (mode),
    .held_o       (held),
    .load_o       (load),
    .snap_o       (snap),
    .shift_step_o (shift_step)
  );

  scc_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .shift_step_i (shift_step),
    .di_i         (di_i),
    .snap_i       (snap),
    .snap_val_i   (cal_q),
    .data_o       (sr_data),
    .do_o         (do_o)
  );

  scc_calendar u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .held_i     (held),
    .load_i     (load),
    .load_val_i (cal_t'(sr_data)),
    .cal_o      (cal_q)
  );

endmodule

// File: rtl/scc_checker.sv
`timescale 1ns/1ps
module scc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        sclk_i,
  input logic        stb_i,
  input logic        do_o,
  input logic        sclk_rise,
  input logic        snap,
  input logic        held,
  input logic        load,
  input logic [1:0]  mode,
  input logic [47:0] cal
);

  // R2
  strobe_sclk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && sclk_i) |=> $stable(mode));

  // R5
  do_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_rise && !snap) |=> $stable(do_o));

  // R10
  held_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !load) |=> $stable(cal));

  // R3
  load_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> held);

  // R7
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !held && !load && cal[7:0] == 8'h59) |=> (cal[7:0] == 8'h00));

endmodule

bind serial_calendar_clock scc_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .sclk_i    (sclk_i),
  .stb_i     (stb_i),
  .do_o      (do_o),
  .sclk_rise (sclk_rise),
  .snap      (snap),
  .held      (held),
  .load      (load),
  .mode      (mode),
  .cal       (cal_q)
);

// File: tb/tb_serial_calendar_clock.sv
`timescale 1ns/1ps
module tb_serial_calendar_clock;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sclk = 1'b0, stb = 1'b0, di = 1'b0;
  logic do_w;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  serial_calendar_clock dut (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick),
    .sclk_i (sclk), .stb_i (stb), .di_i (di), .do_o (do_w)
  );

  function automatic logic [47:0] mk(input logic [7:0] yr, input logic [3:0] mo,
      input logic [3:0] wd, input logic [7:0] dy, input logic [7:0] hr,
      input logic [7:0] mi, input logic [7:0] se);
    return {yr, mo, wd, dy, hr, mi, se};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_bit(input logic b);
    di = b; wait_clk(2);
    sclk = 1'b1; wait_clk(2);
    sclk = 1'b0; wait_clk(2);
  endtask

  task automatic send_cmd(input logic [3:0] code);
    for (int i = 0; i < 4; i++) sclk_bit(code[i]);
    stb = 1'b1; wait_clk(2);
    stb = 1'b0; wait_clk(2);
  endtask

  task automatic shift_in(input logic [47:0] v);
    send_cmd(4'd1);
    for (int i = 0; i < 48; i++) sclk_bit(v[i]);
  endtask

  task automatic read_time(output logic [47:0] v);
    send_cmd(4'd3);
    send_cmd(4'd1);
    for (int i = 0; i < 48; i++) begin
      v[i] = do_w;
      sclk_bit(1'b0);
    end
  endtask

  task automatic set_time(input logic [47:0] v);
    shift_in(v);
    send_cmd(4'd2);
    send_cmd(4'd0);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; wait_clk(1);
    tick = 1'b0; wait_clk(1);
  endtask

  task automatic t_reset();
    logic [47:0] v, e;
    chk(do_w == 1'b0, "R1 do after reset", {47'd0, do_w}, 48'd0);
    e = mk(8'h00, 4'd1, 4'd0, 8'h01, 8'h00, 8'h00, 8'h00);
    read_time(v);
    chk(v == e, "R1 R4 reset time", v, e);
  endtask

  task automatic t_freeze_window();
    logic [47:0] x, v, e;
    x = mk(8'h24, 4'd3, 4'd2, 8'h15, 8'h10, 8'h30, 8'h45);
    shift_in(x);
    chk(do_w == x[0], "R5 first bit at do", {47'd0, do_w}, {47'd0, x[0]});
    // R6: extra edges past 48 must not move the register
    for (int i = 0; i < 4; i++) sclk_bit(1'b1);
    send_cmd(4'd2);
    repeat (3) pulse_tick();
    read_time(v);
    chk(v == x, "R6 R10 frozen load", v, x);
    pulse_tick();
    e = mk(8'h24, 4'd3, 4'd2, 8'h15, 8'h10, 8'h30, 8'h46);
    read_time(v);
    chk(v == e, "R10 released by snapshot cmd", v, e);
  endtask

  task automatic t_tick_case(input logic [47:0] s, input logic [47:0] e, input string tag);
    logic [47:0] v;
    set_time(s);
    pulse_tick();
    read_time(v);
    chk(v == e, tag, v, e);
  endtask

  task automatic t_strobe_high();
    logic [47:0] s, y, v, e;
    s = mk(8'h05, 4'd7, 4'd3, 8'h04, 8'h08, 8'h00, 8'h20);
    y = mk(8'h77, 4'd9, 4'd1, 8'h11, 8'h11, 8'h11, 8'h11);
    set_time(s);
    shift_in(y);
    // code 2, last bit's rising edge kept high across the strobe
    sclk_bit(1'b0); sclk_bit(1'b1); sclk_bit(1'b0);
    di = 1'b0; wait_clk(2);
    sclk = 1'b1; wait_clk(2);
    stb = 1'b1; wait_clk(2);
    stb = 1'b0; wait_clk(2);
    sclk = 1'b0; wait_clk(2);
    pulse_tick();
    e = mk(8'h05, 4'd7, 4'd3, 8'h04, 8'h08, 8'h00, 8'h21);
    read_time(v);
    chk(v == e, "R2 strobe with sclk high ignored", v, e);
  endtask

  task automatic t_unknown_code();
    logic [47:0] z, v, e;
    z = mk(8'h50, 4'd5, 4'd4, 8'h20, 8'h12, 8'h00, 8'h00);
    shift_in(z);
    send_cmd(4'd2);
    send_cmd(4'd5);
    pulse_tick();
    e = mk(8'h50, 4'd5, 4'd4, 8'h20, 8'h12, 8'h00, 8'h01);
    read_time(v);
    chk(v == e, "R3 code 5 acts as idle and releases", v, e);
  endtask

  task automatic t_do_quiet();
    logic d0;
    set_time(mk(8'h01, 4'd1, 4'd0, 8'h01, 8'h00, 8'h00, 8'h01));
    send_cmd(4'd3);
    d0 = do_w;
    chk(d0 == 1'b1, "R5 snapshot bit0 at do", {47'd0, d0}, 48'd1);
    for (int i = 0; i < 8; i++) sclk_bit(1'b0);
    chk(do_w == d0, "R5 no shift outside shift mode", {47'd0, do_w}, {47'd0, d0});
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_freeze_window();
    t_tick_case(mk(8'h24, 4'd3, 4'd2, 8'h15, 8'h10, 8'h30, 8'h09),
                mk(8'h24, 4'd3, 4'd2, 8'h15, 8'h10, 8'h30, 8'h10), "R7 bcd digit carry");
    t_tick_case(mk(8'h24, 4'd3, 4'd2, 8'h15, 8'h09, 8'h59, 8'h59),
                mk(8'h24, 4'd3, 4'd2, 8'h15, 8'h10, 8'h00, 8'h00), "R7 hour carry");
    t_tick_case(mk(8'h99, 4'd12, 4'd6, 8'h31, 8'h23, 8'h59, 8'h59),
                mk(8'h00, 4'd1, 4'd0, 8'h01, 8'h00, 8'h00, 8'h00), "R8 R9 year wrap");
    t_tick_case(mk(8'h23, 4'd2, 4'd1, 8'h28, 8'h23, 8'h59, 8'h59),
                mk(8'h23, 4'd3, 4'd2, 8'h01, 8'h00, 8'h00, 8'h00), "R8 feb non-leap");
    t_tick_case(mk(8'h24, 4'd2, 4'd1, 8'h28, 8'h23, 8'h59, 8'h59),
                mk(8'h24, 4'd2, 4'd2, 8'h29, 8'h00, 8'h00, 8'h00), "R8 feb leap even tens");
    t_tick_case(mk(8'h12, 4'd2, 4'd3, 8'h29, 8'h23, 8'h59, 8'h59),
                mk(8'h12, 4'd3, 4'd4, 8'h01, 8'h00, 8'h00, 8'h00), "R8 feb 29 odd tens");
    t_tick_case(mk(8'h30, 4'd4, 4'd5, 8'h30, 8'h23, 8'h59, 8'h59),
                mk(8'h30, 4'd5, 4'd6, 8'h01, 8'h00, 8'h00, 8'h00), "R8 R9 30-day month");
    t_strobe_high();
    t_unknown_code();
    t_do_quiet();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule